// File: doc/BRIEF.md
# Eight-Slot ADC Scan Sequencer

This block runs a single ordered pass over eight sample slots for a sampling analog-to-digital converter. Each slot is bound to one of sixteen input channels through two channel-list registers, and a skip mask can leave any slot out of the pass. A scan is launched by a software start bit or by a rising edge on an external timer sync line. The sequencer hands one slot at a time to an external converter as a channel number plus a one-cycle request. It waits for the converter's done strobe and latches the returned code into that slot's result register.

Software reaches every register through a simple word-wide register port. Read data is combinational from the address. A status word shows a busy bit, one ready bit per slot and a sticky end-of-scan flag. The flag raises an interrupt line when its enable bit is set. A hold bit in the control register freezes the pass between conversions without losing progress.

Register addresses: 0 control (bit 0 start, write-only; bit 1 hold; bit 2 sync enable; bit 3 end-of-scan interrupt enable). 1 and 2 are the channel lists. 3 is the skip mask in bits 7:0. 4 is status. 8+s is the result of slot s, zero-extended.

Top module: `scan_seq_top`

## Requirements
- R1: Writing address 0 with bit 0 set while idle starts a scan, and status bit 8 (busy) reads 1 from the next cycle.
- R2: Enabled slots are converted in ascending slot order, and slots whose bit is set in the skip mask (address 3) are passed over. During a conversion, convChan carries the 4-bit field of that slot: slot s in 0..3 from address 1 bits 4s+3:4s, and slot s in 4..7 from address 2 bits 4(s-4)+3:4(s-4).
- R3: When convDone is high during a conversion for slot s, convCode is stored at address 8+s and status bit s (ready) is set.
- R4: A read access to address 8+s clears status bit s. A store into the same slot in the same cycle wins.
- R5: When no enabled slot is left, the busy bit clears and status bit 9 (end-of-scan) sets in the same cycle. A scan with every slot skipped ends with no conversion request.
- R6: Writing status with bit 9 set clears the end-of-scan flag, and writing 0 there leaves it unchanged.
- R7: irqEos is high exactly while the end-of-scan flag and control bit 3 are both set.
- R8: While control bit 1 (hold) is set, no new conversion request is issued, and a conversion already requested still completes. Clearing the bit resumes the pass where it stopped.
- R9: With control bit 2 set, a rising edge on syncIn starts a scan. With it clear, syncIn is ignored, and a level held high starts no second scan.
- R10: A start write or sync edge that arrives while a scan is busy is ignored.
- R11: convReq is a one-cycle pulse, and no new request is issued before the previous one has received convDone.
- R12: After reset, all registers and status read 0, and convReq and irqEos are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect: clears ready on result reads) |
| regAddr | input | 4 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, combinational from regAddr |
| syncIn | input | 1 | External timer sync; rising edge can start a scan |
| convReq | output | 1 | One-cycle conversion request |
| convChan | output | 4 | Channel to convert |
| convDone | input | 1 | Converter result valid |
| convCode | input | CODE_W | Converter result code |
| irqEos | output | 1 | End-of-scan interrupt |

## Verification
The bench targets the skip mask: a fully skipped pass must still end and set end-of-scan, and a design that waited for a conversion would hang busy forever. It sets the hold bit before and during a pass, where a sequencer that ignored it would keep issuing requests, or one that dropped the in-flight conversion would lose a ready bit. Start writes and sync edges during a busy pass are repeated to catch a sequencer that restarts and converts more than eight slots. A sync level that stays high is checked to start no second scan. The write-one-to-clear flag is exercised with a zero write, which a plain register write would wrongly clear.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int SLOT_CNT = 8;
  localparam int SLOT_W   = $clog2(SLOT_CNT);
  localparam int CHAN_W   = 4;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = SLOT_W + 1;
  localparam int LIST_W   = SLOT_CNT * CHAN_W;

  localparam logic [ADDR_W-1:0] ADDR_CTRL    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_LIST_LO = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_LIST_HI = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_SKIP    = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADDR_STATUS  = ADDR_W'(4);

  localparam int CTRL_START = 0;
  localparam int CTRL_HOLD  = 1;
  localparam int CTRL_SYNC  = 2;
  localparam int CTRL_IRQ   = 3;
  localparam int STAT_BUSY  = SLOT_CNT;
  localparam int STAT_EOS   = SLOT_CNT + 1;

  typedef struct packed {
    logic              storeEn;
    logic              scanDone;
    logic [SLOT_W-1:0] slot;
  } seqStrobe_t;
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                startTrig,
  input  logic                holdReq,
  input  logic [SLOT_CNT-1:0] skipMask,
  input  logic                convDone,
  output logic                convReq,
  output seqStrobe_t          strobe,
  output logic                busy,
  output logic                waiting
);
  logic [SLOT_CNT-1:0] pending;
  logic [SLOT_W-1:0]   curSlot;
  logic [SLOT_W-1:0]   nextSlot;
  logic                launch;
  logic                scanStart;

  // lowest pending slot wins
  always_comb begin
    nextSlot = '0;
    for (int i = SLOT_CNT - 1; i >= 0; i--) begin
      if (pending[i]) nextSlot = SLOT_W'(i);
    end
  end

  assign launch          = busy && !waiting && (pending != '0) && !holdReq;
  assign scanStart       = !busy && startTrig;
  assign strobe.storeEn  = waiting && convDone;
  assign strobe.scanDone = busy && !waiting && (pending == '0);
  assign strobe.slot     = curSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      waiting <= 1'b0;
      pending <= '0;
      curSlot <= '0;
      convReq <= 1'b0;
    end else begin
      convReq <= launch;
      if (scanStart) begin
        busy    <= 1'b1;
        pending <= ~skipMask;
      end
      if (launch) begin
        waiting <= 1'b1;
        curSlot <= nextSlot;
      end
      if (strobe.storeEn) begin
        waiting          <= 1'b0;
        pending[curSlot] <= 1'b0;
      end
      if (strobe.scanDone) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_seq_regs.sv
module scan_seq_regs
  import scan_seq_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wrData,
  output logic [REG_W-1:0]    rdData,
  input  logic                syncIn,
  input  logic [CODE_W-1:0]   convCode,
  input  seqStrobe_t          strobe,
  input  logic                busy,
  output logic                startTrig,
  output logic                holdReq,
  output logic [SLOT_CNT-1:0] skipMask,
  output logic [CHAN_W-1:0]   convChan,
  output logic                irqEos,
  output logic                eosFlag,
  output logic [SLOT_CNT-1:0] readyBits
);
  localparam int RES_W = SLOT_CNT * CODE_W;

  logic               syncEn;
  logic               irqEn;
  logic               syncPrev;
  logic [REG_W-1:0]   listLo;
  logic [REG_W-1:0]   listHi;
  logic [LIST_W-1:0]  chanFlat;
  logic [RES_W-1:0]   resultFlat;
  logic               ctrlWr;
  logic               statWr;

  assign ctrlWr    = wrEn && (addr == ADDR_CTRL);
  assign statWr    = wrEn && (addr == ADDR_STATUS);
  assign startTrig = (ctrlWr && wrData[CTRL_START]) || (syncEn && syncIn && !syncPrev);
  assign chanFlat  = {listHi, listLo};
  assign convChan  = chanFlat[int'(strobe.slot) * CHAN_W +: CHAN_W];
  assign irqEos    = eosFlag && irqEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReq  <= 1'b0;
      syncEn   <= 1'b0;
      irqEn    <= 1'b0;
      syncPrev <= 1'b0;
      listLo   <= '0;
      listHi   <= '0;
      skipMask <= '0;
      eosFlag  <= 1'b0;
    end else begin
      syncPrev <= syncIn;
      if (ctrlWr) begin
        holdReq <= wrData[CTRL_HOLD];
        syncEn  <= wrData[CTRL_SYNC];
        irqEn   <= wrData[CTRL_IRQ];
      end
      if (wrEn && addr == ADDR_LIST_LO) listLo <= wrData;
      if (wrEn && addr == ADDR_LIST_HI) listHi <= wrData;
      if (wrEn && addr == ADDR_SKIP) skipMask <= wrData[SLOT_CNT-1:0];
      if (strobe.scanDone) eosFlag <= 1'b1;
      else if (statWr && wrData[STAT_EOS]) eosFlag <= 1'b0;
    end
  end

  for (genvar g = 0; g < SLOT_CNT; g++) begin : gSlot
    logic [CODE_W-1:0] value;
    logic              rdy;
    logic              storeHit;
    logic              readHit;
    assign storeHit = strobe.storeEn && (strobe.slot == SLOT_W'(g));
    assign readHit  = rdEn && (addr == {1'b1, SLOT_W'(g)});
    always_ff @(posedge clk) begin
      if (!rstN) begin
        value <= '0;
        rdy   <= 1'b0;
      end else if (storeHit) begin
        value <= convCode;
        rdy   <= 1'b1;
      end else if (readHit) begin
        rdy   <= 1'b0;
      end
    end
    assign resultFlat[g*CODE_W +: CODE_W] = value;
    assign readyBits[g] = rdy;
  end

  always_comb begin
    rdData = '0;
    if (addr[ADDR_W-1]) begin
      rdData = REG_W'(resultFlat[int'(addr[SLOT_W-1:0]) * CODE_W +: CODE_W]);
    end else begin
      case (addr)
        ADDR_CTRL: begin
          rdData[CTRL_HOLD] = holdReq;
          rdData[CTRL_SYNC] = syncEn;
          rdData[CTRL_IRQ]  = irqEn;
        end
        ADDR_LIST_LO: rdData = listLo;
        ADDR_LIST_HI: rdData = listHi;
        ADDR_SKIP:    rdData[SLOT_CNT-1:0] = skipMask;
        ADDR_STATUS: begin
          rdData[SLOT_CNT-1:0] = readyBits;
          rdData[STAT_BUSY]    = busy;
          rdData[STAT_EOS]     = eosFlag;
        end
        default: rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [3:0]        regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              syncIn,
  output logic              convReq,
  output logic [3:0]        convChan,
  input  logic              convDone,
  input  logic [CODE_W-1:0] convCode,
  output logic              irqEos
);
  seqStrobe_t          strobe;
  logic                busy;
  logic                waiting;
  logic                startTrig;
  logic                holdReq;
  logic                eosFlag;
  logic [SLOT_CNT-1:0] skipMask;
  logic [SLOT_CNT-1:0] readyBits;

  scan_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startTrig(startTrig),
    .holdReq  (holdReq),
    .skipMask (skipMask),
    .convDone (convDone),
    .convReq  (convReq),
    .strobe   (strobe),
    .busy     (busy),
    .waiting  (waiting)
  );

  scan_seq_regs #(.CODE_W(CODE_W)) regs_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (regWrEn),
    .rdEn     (regRdEn),
    .addr     (regAddr),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .syncIn   (syncIn),
    .convCode (convCode),
    .strobe   (strobe),
    .busy     (busy),
    .startTrig(startTrig),
    .holdReq  (holdReq),
    .skipMask (skipMask),
    .convChan (convChan),
    .irqEos   (irqEos),
    .eosFlag  (eosFlag),
    .readyBits(readyBits)
  );
endmodule

// File: rtl/scan_seq_checker.sv
module scan_seq_checker
  import scan_seq_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                convReq,
  input logic                holdReq,
  input logic                busy,
  input logic                waiting,
  input logic                eosFlag,
  input seqStrobe_t          strobe,
  input logic [SLOT_CNT-1:0] readyBits
);
  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    convReq |=> !convReq);

  assert_req_outstanding_R11: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> waiting);

  assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convReq) |-> (!$past(holdReq) && $past(busy)));

  assert_end_sets_eos_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (eosFlag && !$past(waiting)));

  assert_store_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeEn |=> readyBits[$past(strobe.slot)]);
endmodule

bind scan_seq_top scan_seq_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .convReq  (convReq),
  .holdReq  (holdReq),
  .busy     (busy),
  .waiting  (waiting),
  .eosFlag  (eosFlag),
  .strobe   (strobe),
  .readyBits(readyBits)
);

// File: tb/scan_seq_top_tb_top.sv
module scan_seq_top_tb_top;
  localparam int CODE_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic syncIn = 1'b0;
  logic convReq;
  logic [3:0] convChan;
  logic convDone = 1'b0;
  logic [CODE_W-1:0] convCode = '0;
  logic irqEos;

  always #10 clk = ~clk;

  scan_seq_top #(.CODE_W(CODE_W)) dut_i (.*);

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // converter model
  int convLat = 1;
  int cnt = 0;
  bit convBusy = 0;
  logic [3:0] chanHold;
  logic [7:0] seqCnt = 8'h11;
  int reqCount = 0;
  always @(negedge clk) begin
    convDone <= 1'b0;
    if (convBusy) begin
      if (cnt == 0) begin
        convDone <= 1'b1;
        convCode <= {chanHold, seqCnt};
        seqCnt   <= seqCnt + 8'h07;
        convBusy = 0;
      end else cnt--;
    end
    if (convReq) begin
      convBusy = 1;
      cnt = convLat;
      chanHold = convChan;
      reqCount++;
    end
  end

  // behavioural reference model
  bit mBusy, mWait, mReq, mEos, mHold, mSync, mIrq, mSyncPrev;
  int mQ[$];
  int mCur;
  logic [15:0] mLo, mHi;
  logic [7:0] mSkip, mReady;
  logic [CODE_W-1:0] mRes[8];

  function automatic logic [3:0] expChan(int s);
    logic [31:0] f = {mHi, mLo};
    return f[s*4 +: 4];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mWait = 0; mReq = 0; mEos = 0; mHold = 0; mSync = 0; mIrq = 0;
      mSyncPrev = 0; mQ.delete(); mCur = 0; mLo = 0; mHi = 0; mSkip = 0; mReady = 0;
      for (int i = 0; i < 8; i++) mRes[i] = '0;
    end else begin
      bit trig, store, done, launch, oldBusy;
      oldBusy = mBusy;
      trig = (regWrEn && regAddr == 0 && regWrData[0]) || (mSync && syncIn && !mSyncPrev);
      store = mWait && convDone;
      done = mBusy && !mWait && mQ.size() == 0;
      launch = mBusy && !mWait && mQ.size() != 0 && !mHold;
      if (regRdEn && regAddr >= 8) mReady[regAddr-8] = 1'b0;
      if (store) begin mRes[mCur] = convCode; mReady[mCur] = 1'b1; mWait = 0; end
      if (launch) begin mCur = mQ.pop_front(); mWait = 1; end
      if (done) begin mBusy = 0; mEos = 1; end
      else if (regWrEn && regAddr == 4 && regWrData[9]) mEos = 0;
      if (!oldBusy && trig) begin
        mBusy = 1;
        mQ.delete();
        for (int i = 0; i < 8; i++) if (!mSkip[i]) mQ.push_back(i);
      end
      if (regWrEn) begin
        case (regAddr)
          4'd0: begin mHold = regWrData[1]; mSync = regWrData[2]; mIrq = regWrData[3]; end
          4'd1: mLo = regWrData;
          4'd2: mHi = regWrData;
          4'd3: mSkip = regWrData[7:0];
          default: ;
        endcase
      end
      mSyncPrev = syncIn;
      mReq = launch;
    end
  end

  // per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rstN) begin
      check(convReq == mReq, "R11 convReq", convReq, mReq);
      if (mReq) check(convChan == expChan(mCur), "R2 convChan", convChan, expChan(mCur));
      check(irqEos == (mEos && mIrq), "R7 irqEos", irqEos, mEos && mIrq);
    end
  end

  task automatic writeReg(logic [3:0] a, logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(logic [3:0] a, output logic [15:0] v);
    regRdEn = 1'b1; regAddr = a;
    #1 v = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  function automatic logic [15:0] expStatus();
    return {6'b0, mEos, mBusy, mReady};
  endfunction

  task automatic checkStatus(string tag);
    logic [15:0] v;
    logic [15:0] e;
    e = expStatus();
    readReg(4'd4, v);
    check(v == e, tag, v, e);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (mBusy && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    checkStatus("R12 status after reset");
    readReg(4'd0, v); check(v == 0, "R12 control after reset", v, 0);
    check(convReq == 0 && irqEos == 0, "R12 outputs after reset", {convReq, irqEos}, 0);

    // R1 R2 R3 R5 R7 full scan
    writeReg(4'd1, 16'hA5C3);
    writeReg(4'd2, 16'h7E19);
    writeReg(4'd0, 16'h0008);
    base = reqCount;
    writeReg(4'd0, 16'h0009);
    checkStatus("R1 busy after start");
    waitIdle();
    checkStatus("R5 end of full scan");
    check(reqCount - base == 8, "R2 conversions in full scan", reqCount - base, 8);
    check(irqEos == 1, "R7 irq raised", irqEos, 1);
    for (int s = 0; s < 8; s++) begin
      readReg(4'(8 + s), v);
      check(v == 16'(mRes[s]), "R3 result value", v, mRes[s]);
    end
    checkStatus("R4 ready cleared by reads");

    // R6 write-one-to-clear
    writeReg(4'd4, 16'h0000);
    checkStatus("R6 zero write keeps flag");
    writeReg(4'd4, 16'h0200);
    checkStatus("R6 flag cleared");
    check(irqEos == 0, "R7 irq dropped", irqEos, 0);

    // R2 skip mask, longer latency
    convLat = 2;
    writeReg(4'd3, 16'h00A5);
    base = reqCount;
    writeReg(4'd0, 16'h0001);
    waitIdle();
    checkStatus("R2 ready pattern with skips");
    check(reqCount - base == 4, "R2 conversions with skips", reqCount - base, 4);
    readReg(4'd9, v);
    checkStatus("R4 single ready cleared");

    // R5 all slots skipped
    writeReg(4'd3, 16'h00FF);
    writeReg(4'd4, 16'h0200);
    base = reqCount;
    writeReg(4'd0, 16'h0001);
    waitIdle();
    repeat (3) @(negedge clk);
    checkStatus("R5 empty scan ends");
    check(reqCount - base == 0, "R5 no request in empty scan", reqCount - base, 0);

    // R10 start and sync while busy
    writeReg(4'd3, 16'h0000);
    convLat = 3;
    base = reqCount;
    writeReg(4'd0, 16'h0005);
    repeat (4) @(negedge clk);
    writeReg(4'd0, 16'h0005);
    syncIn = 1'b1; @(negedge clk); syncIn = 1'b0;
    waitIdle();
    repeat (4) @(negedge clk);
    check(reqCount - base == 8, "R10 restart ignored", reqCount - base, 8);
    checkStatus("R10 status after ignored restart");

    // R9 sync disabled, then enabled, then held high
    writeReg(4'd0, 16'h0000);
    writeReg(4'd4, 16'h0200);
    syncIn = 1'b1; @(negedge clk); syncIn = 1'b0;
    @(negedge clk);
    checkStatus("R9 sync ignored when disabled");
    writeReg(4'd0, 16'h0004);
    base = reqCount;
    syncIn = 1'b1;
    @(negedge clk);
    checkStatus("R9 sync edge starts scan");
    waitIdle();
    repeat (10) @(negedge clk);
    checkStatus("R9 held sync does not restart");
    check(reqCount - base == 8, "R9 one scan from sync", reqCount - base, 8);
    syncIn = 1'b0;
    writeReg(4'd0, 16'h0000);

    // R8 hold before and during a scan
    convLat = 1;
    base = reqCount;
    writeReg(4'd0, 16'h0003);
    repeat (20) @(negedge clk);
    check(reqCount - base == 0, "R8 hold blocks requests", reqCount - base, 0);
    checkStatus("R8 busy while held");
    writeReg(4'd0, 16'h0000);
    waitIdle();
    check(reqCount - base == 8, "R8 resume after hold", reqCount - base, 8);
    writeReg(4'd4, 16'h0200);
    base = reqCount;
    writeReg(4'd0, 16'h0001);
    while (reqCount - base < 3) @(negedge clk);
    writeReg(4'd0, 16'h0002);
    base = reqCount;
    repeat (20) @(negedge clk);
    check(reqCount - base <= 1, "R8 no new request mid-scan", reqCount - base, 1);
    checkStatus("R8 in-flight conversion kept");
    writeReg(4'd0, 16'h0000);
    waitIdle();
    checkStatus("R8 scan completes after release");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule